// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block turns a digital supply-good indication into an escalating power-down sequence for a host processor. When the supply leaves tolerance during normal operation, the block raises a level power-down interrupt. The host then has time to save its state. The block also starts two independent deadlines. The first is a short watchdog-fault window, measured on a freshly cleared watchdog counter. The second is a long forced-reset deadline. The host can finish early by requesting its own reset. Whichever path comes first puts the system into reset.

In normal operation the same watchdog runs with a longer timeout, and each kick strobe from the host restarts it. On expiry the block raises the fault output and asserts system reset. System reset is held while the supply-good input is low. It is released only after the input has stayed high for a stabilisation time. A single prescaler derives a 1 ms tick from the `CLK_HZ` parameter, and all time values are given in milliseconds.

The block has three states. In reset, the system reset output is high. In normal operation, all three outputs follow the watchdog. In power-down, the interrupt output is high. Once power-down is entered it can only end in reset. A return of the supply during power-down does not cancel it.

Top module: `pwr_fail_seq`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1 and `pd_irq_o` and `wd_fault_o` are 0. This takes effect without waiting for a clock edge.
- R2: `sys_rst_o` stays 1 while `pwr_good_i` is low. It falls exactly `STABLE_MS` ms after the first clock edge at which `pwr_good_i` is sampled high, counted from the last edge at which it was sampled low or from reset release. Any low sample restarts this wait.
- R3: In normal operation, if `pwr_good_i` is sampled low at an edge, `pd_irq_o` is 1 from that edge. It stays 1 until `sys_rst_o` rises, and it falls on that same edge. The two outputs are never 1 together. `pwr_good_i` going high again during power-down has no effect.
- R4: On power-down entry the watchdog count is cleared. `wd_fault_o` rises exactly `WD_FAULT_MS` ms after the entry edge, whatever count the watchdog held before entry.
- R5: `FORCE_RST_MS` ms after the power-down entry edge, `sys_rst_o` rises even if the host takes no action.
- R6: If `host_rst_req_i` is sampled high in normal operation or in power-down, `sys_rst_o` is 1 from that edge. This has priority over a same-cycle supply drop. If the request comes before the fault window ends, `wd_fault_o` never rises for that power-down.
- R7: In normal operation, if no `wd_kick_i` arrives for more than `WD_TIMEOUT_MS - 1` ms and at most `WD_TIMEOUT_MS` ms, `wd_fault_o` and `sys_rst_o` both rise. Each kick restarts this count. `wd_fault_o` stays 1 until `sys_rst_o` falls.
- R8: `wd_fault_o` may only fall on the edge at which `sys_rst_o` falls.
- R9: Kick strobes during power-down are ignored. The fault window and the forced-reset deadline keep their timing whatever kicks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Debounced supply-good indication, 1 = in tolerance |
| wd_kick_i | input | 1 | Watchdog restart strobe from the host |
| host_rst_req_i | input | 1 | Host request for its own reset |
| pd_irq_o | output | 1 | Power-down interrupt, level |
| wd_fault_o | output | 1 | Watchdog fault |
| sys_rst_o | output | 1 | System reset, active high |

## Verification
The checker watches the cycle-level relations that hold in every cycle:
- the interrupt and the reset are never high together;
- the interrupt starts only after a low supply sample and ends only into reset;
- a host request always gives reset on the next cycle;
- reset holds while the supply is low;
- the fault clears only as reset releases.

The exact millisecond positions can only be shown by the bench's timed scenarios. These are the stabilisation wait and its restart after a glitch, the 4 ms fault window after a long-running watchdog count, the 900 ms forced reset and the normal-mode timeout after a kick. The same applies to kicks having no effect during power-down, and to an early host reset that suppresses the fault.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PDOWN = 2'd2
  } pfs_state_e;
endpackage

// File: rtl/pfs_prescaler.sv
module pfs_prescaler #(
  parameter int DIV = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pfs_ms_timer.sv
module pfs_ms_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign cnt_o = cnt_q;

  // saturating millisecond count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clr_i)                      cnt_q <= '0;
    else if (tick_i && (cnt_q != '1))    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
  import pfs_pkg::*;
#(
  parameter int CLK_HZ        = 50_000_000,
  parameter int WD_TIMEOUT_MS = 1000,
  parameter int WD_FAULT_MS   = 4,
  parameter int FORCE_RST_MS  = 900,
  parameter int STABLE_MS     = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic wd_kick_i,
  input  logic host_rst_req_i,
  output logic pd_irq_o,
  output logic wd_fault_o,
  output logic sys_rst_o
);
  localparam int DIV    = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
  localparam int WD_MAX = (WD_TIMEOUT_MS > WD_FAULT_MS) ? WD_TIMEOUT_MS : WD_FAULT_MS;
  localparam int PD_MAX = (FORCE_RST_MS > STABLE_MS) ? FORCE_RST_MS : STABLE_MS;
  localparam int WD_W   = $clog2(WD_MAX + 1);
  localparam int PD_W   = $clog2(PD_MAX + 1);
  localparam logic [WD_W-1:0] WDT_LAST   = WD_W'(WD_TIMEOUT_MS - 1);
  localparam logic [WD_W-1:0] FAULT_LAST = WD_W'(WD_FAULT_MS - 1);
  localparam logic [PD_W-1:0] FORCE_LAST = PD_W'(FORCE_RST_MS - 1);
  localparam logic [PD_W-1:0] STAB_LAST  = PD_W'(STABLE_MS - 1);

  pfs_state_e state_q, state_d;
  logic       fault_q, fault_d;
  logic       tick, state_chg, presc_clr, wd_clr, pd_clr;
  logic [WD_W-1:0] wd_cnt;
  logic [PD_W-1:0] pd_cnt;

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    unique case (state_q)
      ST_HOLD: begin
        if (pwr_good_i && tick && (pd_cnt == STAB_LAST)) begin
          state_d = ST_RUN;
          fault_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (host_rst_req_i) begin
          state_d = ST_HOLD;
        end else if (!pwr_good_i) begin
          state_d = ST_PDOWN;
        end else if (!wd_kick_i && tick && (wd_cnt == WDT_LAST)) begin
          state_d = ST_HOLD;
          fault_d = 1'b1;
        end
      end
      ST_PDOWN: begin
        if (host_rst_req_i) begin
          state_d = ST_HOLD;
        end else begin
          if (tick && (pd_cnt == FORCE_LAST)) state_d = ST_HOLD;
          if (tick && (wd_cnt == FAULT_LAST)) fault_d = 1'b1;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  assign state_chg = (state_d != state_q);
  // realign the ms grid on every state change and on a low sample in hold
  assign presc_clr = state_chg || ((state_q == ST_HOLD) && !pwr_good_i);
  assign pd_clr    = presc_clr;
  // kicks restart the watchdog only in normal operation
  assign wd_clr    = state_chg || ((state_q == ST_RUN) && wd_kick_i);

  pfs_prescaler #(.DIV(DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (presc_clr),
    .tick_o (tick)
  );

  pfs_ms_timer #(.W(WD_W)) u_wd_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wd_clr),
    .tick_i (tick),
    .cnt_o  (wd_cnt)
  );

  pfs_ms_timer #(.W(PD_W)) u_pd_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pd_clr),
    .tick_i (tick),
    .cnt_o  (pd_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  assign sys_rst_o  = (state_q == ST_HOLD);
  assign pd_irq_o   = (state_q == ST_PDOWN);
  assign wd_fault_o = fault_q;
endmodule

// File: rtl/pwr_fail_seq_chk.sv
module pwr_fail_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_good_i,
  input logic host_rst_req_i,
  input logic pd_irq_o,
  input logic wd_fault_o,
  input logic sys_rst_o
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |-> (sys_rst_o && !pd_irq_o && !wd_fault_o));

  a_r2_hold_while_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_o && !pwr_good_i) |=> sys_rst_o);

  a_r3_irq_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pd_irq_o && sys_rst_o));

  a_r3_irq_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_irq_o) |-> !$past(pwr_good_i));

  a_r3_irq_until_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_irq_o) |-> sys_rst_o);

  a_r6_host_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rst_req_i |=> sys_rst_o);

  a_r8_fault_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wd_fault_o) |-> $fell(sys_rst_o));
endmodule

bind pwr_fail_seq pwr_fail_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pwr_good_i     (pwr_good_i),
  .host_rst_req_i (host_rst_req_i),
  .pd_irq_o       (pd_irq_o),
  .wd_fault_o     (wd_fault_o),
  .sys_rst_o      (sys_rst_o)
);

// File: tb/pwr_fail_seq_test.sv
`timescale 1ns/1ps
module pwr_fail_seq_test;
  // 10 cycles per ms with CLK_HZ = 10_000
  localparam int CLK_HZ = 10_000;

  typedef struct packed {
    logic        pg;
    logic        kick;
    logic        req;
    logic [15:0] wait_n;
    logic        irq;
    logic        flt;
    logic        rst;
    logic [7:0]  req_no;
  } vec_t;

  function automatic vec_t mk(bit pg, bit k, bit r, int w, bit i, bit f, bit s, int n);
    vec_t v;
    v.pg = pg; v.kick = k; v.req = r; v.wait_n = w[15:0];
    v.irq = i; v.flt = f; v.rst = s; v.req_no = n[7:0];
    return v;
  endfunction

  // edges counted from reset release; comments give the edge reached
  localparam vec_t VEC [16] = '{
    mk(1,0,0, 97, 0,0,1, 2),  // E97  R2 still in stabilisation
    mk(1,0,0,  5, 0,0,0, 2),  // E102 R2 released at E100
    mk(1,0,0,150, 0,0,0, 7),  // E252 R7 before first timeout
    mk(1,1,0,  1, 0,0,0, 7),  // E253 R7 kick
    mk(1,0,0,190, 0,0,0, 7),  // E443 R7 restarted by kick
    mk(1,0,0, 12, 0,1,1, 7),  // E455 R7 timeout at E450
    mk(1,0,0, 90, 0,1,1, 7),  // E545 R7 fault held in reset
    mk(1,0,0, 10, 0,0,0, 8),  // E555 R8 fault clears with reset
    mk(0,0,0,  1, 1,0,0, 3),  // E556 R3 power-down entry
    mk(0,1,0,  1, 1,0,0, 9),  // E557 R9 kick ignored
    mk(0,0,0, 37, 1,0,0, 4),  // E594 R4 before window
    mk(0,0,0,  4, 1,1,0, 4),  // E598 R4 fault at E596
    mk(1,0,0,100, 1,1,0, 3),  // E698 R3 supply return ignored
    mk(1,0,1,  1, 0,1,1, 6),  // E699 R6 host reset
    mk(1,0,0, 98, 0,1,1, 2),  // E797 R2 waiting
    mk(1,0,0,  5, 0,0,0, 2)   // E802 R2 released
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, kick = 1'b0, req = 1'b0;
  logic irq, flt, srst;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pwr_fail_seq #(
    .CLK_HZ(CLK_HZ), .WD_TIMEOUT_MS(20), .WD_FAULT_MS(4),
    .FORCE_RST_MS(900), .STABLE_MS(10)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .wd_kick_i(kick),
    .host_rst_req_i(req), .pd_irq_o(irq), .wd_fault_o(flt), .sys_rst_o(srst)
  );

  task automatic chk(string tag, logic ei, logic ef, logic es);
    checks++;
    if (irq !== ei || flt !== ef || srst !== es) begin
      fails++;
      $display("FAIL %s: irq/fault/rst actual=%b%b%b expected=%b%b%b",
               tag, irq, flt, srst, ei, ef, es);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    pg = 1'b1;
    step(3);
    chk("R1 reset state", 0, 0, 1);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      pg = VEC[i].pg; kick = VEC[i].kick; req = VEC[i].req;
      step(int'(VEC[i].wait_n));
      chk($sformatf("R%0d row %0d", VEC[i].req_no, i), VEC[i].irq, VEC[i].flt, VEC[i].rst);
    end
    kick = 1'b0; req = 1'b0;

    // R5 forced reset at 9000 edges after entry
    pg = 1'b0; step(1);
    chk("R3 entry", 1, 0, 0);
    step(8997);
    chk("R5 before deadline", 1, 1, 0);
    step(4);
    chk("R5 forced reset", 0, 1, 1);
    step(200);
    chk("R2 held while low", 0, 1, 1);

    // R2 glitch restarts stabilisation
    pg = 1'b1; step(60);
    pg = 1'b0; step(1);
    pg = 1'b1; step(98);
    chk("R2 glitch restart", 0, 1, 1);
    step(4);
    chk("R2 release after glitch", 0, 0, 0);

    // R4 count cleared on entry, R9 kicks ignored
    step(48);
    chk("R7 no timeout yet", 0, 0, 0);
    pg = 1'b0; step(1);
    for (int k = 0; k < 7; k++) begin
      kick = 1'b1; step(1);
      kick = 1'b0; step(4);
    end
    chk("R9 kicks ignored before window", 1, 0, 0);
    kick = 1'b1; step(1);
    kick = 1'b0; step(4);
    chk("R4 R9 fault on time", 1, 1, 0);
    req = 1'b1; step(1);
    req = 1'b0;
    chk("R6 host reset in power-down", 0, 1, 1);
    pg = 1'b1; step(102);
    chk("R2 release", 0, 0, 0);

    // R6 early host request suppresses fault
    pg = 1'b0; step(21);
    chk("R4 inside window", 1, 0, 0);
    req = 1'b1; step(1);
    req = 1'b0;
    chk("R6 early host reset", 0, 0, 1);
    step(100);
    chk("R6 no fault after early reset", 0, 0, 1);
    pg = 1'b1; step(102);
    chk("R2 release", 0, 0, 0);

    // R6 host request in normal operation, with simultaneous supply drop
    req = 1'b1; pg = 1'b0; step(1);
    req = 1'b0;
    chk("R6 request beats drop", 0, 0, 1);
    pg = 1'b1; step(102);
    chk("R2 release", 0, 0, 0);

    // R1 asynchronous reset mid power-down
    pg = 1'b0; step(50);
    chk("R4 fault before async reset", 1, 1, 0);
    rst_n = 1'b0; #1;
    chk("R1 async reset", 0, 0, 1);
    step(2);
    rst_n = 1'b1; pg = 1'b1; step(102);
    chk("R2 release after reset", 0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule